// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block drives a string of daisy-chained RGB LEDs over a single data wire. It walks through the LED indices in order and puts each index on an address output. External logic or a synchronous colour memory answers with a 24-bit colour. The block shifts that colour onto the wire as pulse-width-coded bits. Each bit is a high pulse followed by a low pulse, and the two lengths tell a 0 from a 1. All LEDs of one frame are sent as one unbroken stream, and every LED keeps the first 24 bits it receives.

After the last LED the line is held low for a latch interval, which makes the chain apply the new colours. The block then starts again at index 0. It does the same after reset. All pulse lengths are given in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `led_chain_driver`

## Requirements
- R1: While `rst_n` is low, `dout_o` is 0 and `led_addr_o` is 0.
- R2: After reset is released, the line stays low and first rises on the LATCH_CYC-th rising clock edge. Between frames, the low time after the last bit is the normal low time of that bit plus LATCH_CYC cycles. LATCH_CYC is the latch time converted to cycles (default 50 µs).
- R3: A 0 bit is T0H_CYC cycles high then T0L_CYC cycles low. A 1 bit is T1H_CYC cycles high then T1L_CYC cycles low.
- R4: On `colour_i`, bits [23:16] are red, [15:8] are green and [7:0] are blue. Each LED is sent as green, then red, then blue, each byte most significant bit first.
- R5: Inside a frame, every bit follows the previous one with no extra low cycles, including across LED boundaries. A frame carries exactly 24 × NUM_LEDS bits.
- R6: `led_addr_o` always holds the index of the next LED to be fetched. It steps by one, from NUM_LEDS-1 back to 0, on the same edge that captures the colour. It has then been stable for at least two edges, so a memory with one cycle of read latency can answer.
- R7: Frames repeat without end. Each frame starts at index 0 and carries the colours present at fetch time.
- R8: Each timing in cycles is floor(ns × CLK_MHZ / 1000), with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| led_addr_o | output | max(1,clog2(NUM_LEDS)) | Index of the LED whose colour is fetched next |
| colour_i | input | 24 | Colour for `led_addr_o`: red [23:16], green [15:8], blue [7:0] |
| dout_o | output | 1 | Serial data line to the first LED |

## Verification
The colour is captured on the edge that ends the previous bit or the latch, and `dout_o` rises right after that edge. The address steps on that same edge. The bench therefore samples on falling clock edges and counts high and low samples per bit. It expects exact counts, with LATCH_CYC added only to the last bit of a frame. The bench reads the address in the first sampled cycle of an LED's first bit, by which time it has already stepped. The bench's colour model is registered, so it has the same one-cycle latency as a memory. The bench changes the colour pattern only while the last LED of a frame is being sent, so every frame is checked against a pattern chosen before its first fetch.

// File: rtl/led_chain_pkg.sv
// Shared types and helpers for the LED chain driver.
// Assumes nanosecond timings and a clock given in whole MHz.
package led_chain_pkg;

    typedef enum logic {
        ST_LATCH = 1'b0,
        ST_SEND  = 1'b1
    } chain_state_t;

    localparam int COLOUR_BITS = 24;

    // Converts a time in ns into clock cycles, never less than one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Reorders {red, green, blue} from the port into wire order {green, red, blue}.
    function automatic logic [COLOUR_BITS-1:0] to_wire_order(input logic [COLOUR_BITS-1:0] rgb);
        return {rgb[15:8], rgb[23:16], rgb[7:0]};
    endfunction

endpackage

// File: rtl/ledc_bit_shaper.sv
// Produces one pulse-width-coded bit per go strobe: a high phase, then a low phase.
// Assumes go_i is only raised when idle or in the cycle done_o is high.
// done_o marks the last low cycle, so a go in that cycle keeps bits back to back.
module ledc_bit_shaper #(
    parameter int T0H_CYC = 40,
    parameter int T0L_CYC = 85,
    parameter int T1H_CYC = 80,
    parameter int T1L_CYC = 45,
    localparam int MAXC   = (T0H_CYC > T1H_CYC ? T0H_CYC : T1H_CYC) +
                            (T0L_CYC > T1L_CYC ? T0L_CYC : T1L_CYC),
    localparam int CW     = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic bit_i,
    output logic done_o,
    output logic dout_o
);

    localparam logic [CW-1:0] H0 = CW'(T0H_CYC - 1);
    localparam logic [CW-1:0] H1 = CW'(T1H_CYC - 1);
    localparam logic [CW-1:0] L0 = CW'(T0L_CYC - 1);
    localparam logic [CW-1:0] L1 = CW'(T1L_CYC - 1);

    logic          busy_q;
    logic          high_q;
    logic          bit_q;
    logic [CW-1:0] cnt_q;

    assign done_o = busy_q && !high_q && (cnt_q == '0);
    assign dout_o = high_q;

    // Phase sequencer: load the high length, then the low length, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            high_q <= 1'b0;
            bit_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            high_q <= 1'b1;
            bit_q  <= bit_i;
            cnt_q  <= bit_i ? H1 : H0;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (high_q) begin
                high_q <= 1'b0;
                cnt_q  <= bit_q ? L1 : L0;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ledc_word_shifter.sv
// Holds the colour word in wire order and shifts it left one bit per sent bit.
// Assumes load_i and shift_i are never high together.
module ledc_word_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             next_bit_o
);

    logic [WIDTH-1:0] sreg_q;

    // The bit after the current MSB is the one sent on the next shift.
    assign next_bit_o = sreg_q[WIDTH-2];

    // Word register: capture on load, move toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/ledc_frame_ctrl.sv
// Frame sequencer: times the latch gap, counts bits per LED and steps the fetch address.
// The address always names the next LED to load. Wrapping to 0 at a load marks the
// last LED of the frame, so no separate LED counter is kept.
module ledc_frame_ctrl
    import led_chain_pkg::*;
#(
    parameter int NUM_LEDS  = 8,
    parameter int LATCH_CYC = 5000,
    localparam int AW       = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1,
    localparam int LCW      = $clog2(LATCH_CYC + 1),
    localparam int BW       = $clog2(COLOUR_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_done_i,
    output logic          load_o,
    output logic          shift_o,
    output logic [AW-1:0] addr_o
);

    localparam logic [LCW-1:0] LAT_LAST  = LCW'(LATCH_CYC - 1);
    localparam logic [BW-1:0]  BIT_LAST  = BW'(COLOUR_BITS - 1);
    localparam logic [AW-1:0]  ADDR_LAST = AW'(NUM_LEDS - 1);

    chain_state_t   state_q;
    logic [LCW-1:0] lcnt_q;
    logic [BW-1:0]  bit_idx_q;
    logic [AW-1:0]  addr_q;
    logic           lat_end;
    logic           word_end;
    logic           frame_end;

    assign lat_end   = (state_q == ST_LATCH) && (lcnt_q == LAT_LAST);
    assign word_end  = (state_q == ST_SEND) && bit_done_i && (bit_idx_q == BIT_LAST);
    assign frame_end = word_end && (addr_q == '0);
    assign addr_o    = addr_q;

    // Strobe decode: load a new colour, or shift to the next bit of the same one.
    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        if (lat_end) begin
            load_o = 1'b1;
        end else if (state_q == ST_SEND && bit_done_i) begin
            if (bit_idx_q == BIT_LAST) begin
                load_o = (addr_q != '0);
            end else begin
                shift_o = 1'b1;
            end
        end
    end

    // State, bit index and address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_LATCH;
            bit_idx_q <= '0;
            addr_q    <= '0;
        end else if (load_o) begin
            state_q   <= ST_SEND;
            bit_idx_q <= '0;
            addr_q    <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
        end else if (shift_o) begin
            bit_idx_q <= bit_idx_q + 1'b1;
        end else if (frame_end) begin
            state_q <= ST_LATCH;
        end
    end

    // Latch timer: counts low cycles while latching and clears at every other time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt_q <= '0;
        end else if (state_q == ST_LATCH && !lat_end) begin
            lcnt_q <= lcnt_q + 1'b1;
        end else begin
            lcnt_q <= '0;
        end
    end

endmodule

// File: rtl/led_chain_driver.sv
// Top of the LED chain driver: sends NUM_LEDS colours as one serial frame, then latches.
// Assumes colour_i follows led_addr_o with at most one cycle of latency.
module led_chain_driver
    import led_chain_pkg::*;
#(
    parameter int NUM_LEDS = 8,
    parameter int CLK_MHZ  = 100,
    parameter int T0H_NS   = 400,
    parameter int T0L_NS   = 850,
    parameter int T1H_NS   = 800,
    parameter int T1L_NS   = 450,
    parameter int LATCH_NS = 50000,
    localparam int AW      = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] led_addr_o,
    input  logic [23:0]   colour_i,
    output logic          dout_o
);

    localparam int T0H_CYC   = ns_to_cyc(T0H_NS, CLK_MHZ);
    localparam int T0L_CYC   = ns_to_cyc(T0L_NS, CLK_MHZ);
    localparam int T1H_CYC   = ns_to_cyc(T1H_NS, CLK_MHZ);
    localparam int T1L_CYC   = ns_to_cyc(T1L_NS, CLK_MHZ);
    localparam int LATCH_CYC = ns_to_cyc(LATCH_NS, CLK_MHZ);

    logic                   load;
    logic                   shift;
    logic                   bit_done;
    logic                   next_bit;
    logic                   go_bit;
    logic [COLOUR_BITS-1:0] wire_word;

    // The first bit of a new word comes straight from the input; later bits from the shifter.
    assign wire_word = to_wire_order(colour_i);
    assign go_bit    = load ? wire_word[COLOUR_BITS-1] : next_bit;

    ledc_frame_ctrl #(
        .NUM_LEDS (NUM_LEDS),
        .LATCH_CYC(LATCH_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_done_i(bit_done),
        .load_o    (load),
        .shift_o   (shift),
        .addr_o    (led_addr_o)
    );

    ledc_word_shifter #(
        .WIDTH(COLOUR_BITS)
    ) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .shift_i   (shift),
        .word_i    (wire_word),
        .next_bit_o(next_bit)
    );

    ledc_bit_shaper #(
        .T0H_CYC(T0H_CYC),
        .T0L_CYC(T0L_CYC),
        .T1H_CYC(T1H_CYC),
        .T1L_CYC(T1L_CYC)
    ) shaper_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (load | shift),
        .bit_i (go_bit),
        .done_o(bit_done),
        .dout_o(dout_o)
    );

endmodule

// File: rtl/led_chain_chk.sv
// Property checker for the LED chain driver, attached to the top by bind.
// Observes only the top ports and keeps its own run-length counters.
module led_chain_chk #(
    parameter int NUM_LEDS  = 8,
    parameter int AW        = 3,
    parameter int T0H_CYC   = 40,
    parameter int T0L_CYC   = 85,
    parameter int T1H_CYC   = 80,
    parameter int T1L_CYC   = 45,
    parameter int LATCH_CYC = 5000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          dout
);

    localparam logic [AW-1:0] ADDR_LAST = AW'(NUM_LEDS - 1);

    logic [AW-1:0] prev_addr_q;
    int            hi_run_q;
    int            lo_run_q;

    // Run-length and previous-address tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr_q <= '0;
            hi_run_q    <= 0;
            lo_run_q    <= 0;
        end else begin
            prev_addr_q <= addr;
            hi_run_q    <= dout ? hi_run_q + 1 : 0;
            lo_run_q    <= dout ? 0 : ((lo_run_q < LATCH_CYC + 1000) ? lo_run_q + 1 : lo_run_q);
        end
    end

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != prev_addr_q) |-> (addr == ((prev_addr_q == ADDR_LAST) ? '0 : prev_addr_q + 1'b1)));

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) < NUM_LEDS));

    // R6
    fetch_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> $past(addr == prev_addr_q));

    // R3
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout) |-> (hi_run_q == T0H_CYC || hi_run_q == T1H_CYC));

    // R5
    low_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> (lo_run_q == T0L_CYC || lo_run_q == T1L_CYC || lo_run_q >= LATCH_CYC));

endmodule

bind led_chain_driver led_chain_chk #(
    .NUM_LEDS (NUM_LEDS),
    .AW       (AW),
    .T0H_CYC  (T0H_CYC),
    .T0L_CYC  (T0L_CYC),
    .T1H_CYC  (T1H_CYC),
    .T1L_CYC  (T1L_CYC),
    .LATCH_CYC(LATCH_CYC)
) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (led_addr_o),
    .dout (dout_o)
);

// File: tb/led_chain_driver_tb_top.sv
// Bench: three LEDs at 250 MHz with short timings. It decodes every bit of four frames.
module led_chain_driver_tb_top;

    localparam int N      = 3;
    localparam int MHZ    = 250;
    localparam int AW     = 2;
    // R8: expected cycle counts computed here as ns * MHz / 1000
    localparam int E_T0H  = 40 * MHZ / 1000;
    localparam int E_T0L  = 60 * MHZ / 1000;
    localparam int E_T1H  = 80 * MHZ / 1000;
    localparam int E_T1L  = 20 * MHZ / 1000;
    localparam int E_LAT  = 400 * MHZ / 1000;
    localparam int FRAMES = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic [23:0]   colour_q = '0;
    logic          dout;
    int            pat = 0;
    int            n_checks = 0;
    int            n_fails = 0;
    bit            finished = 1'b0;

    always #2 clk = ~clk;

    led_chain_driver #(
        .NUM_LEDS(N), .CLK_MHZ(MHZ),
        .T0H_NS(40), .T0L_NS(60), .T1H_NS(80), .T1L_NS(20), .LATCH_NS(400)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .led_addr_o(addr),
        .colour_i  (colour_q),
        .dout_o    (dout)
    );

    // Colour patterns, port layout {red, green, blue}.
    function automatic logic [23:0] colour_of(input int a, input int p);
        case (p)
            0:       return 24'h000000;
            1:       return 24'hFFFFFF;
            2:       return 24'hA53C0F ^ {3{8'(a)}};
            default: return {8'(a * 17 + 1), 8'(a * 29 + 128), 8'(255 - a * 40)};
        endcase
    endfunction

    // Memory model with one cycle of read latency.
    always @(posedge clk) colour_q <= colour_of(int'(addr), pat);

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Counts high then low samples of the bit that has just started.
    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (dout == 1'b1 && hi < 1000) begin
            hi++;
            @(negedge clk);
        end
        while (dout == 1'b0 && lo < E_LAT + 1000) begin
            lo++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(dout == 1'b0 && addr == '0,
              $sformatf("R1 reset: dout %0b addr %0d, expected 0 0", dout, addr));
        rst_n = 1'b1;
        lo0 = 0;
        @(negedge clk);
        while (dout == 1'b0 && lo0 < E_LAT + 1000) begin
            lo0++;
            @(negedge clk);
        end
        // R2: first rise on edge E_LAT, so E_LAT-1 low samples follow the release
        check(lo0 == E_LAT - 1,
              $sformatf("R2 first latch: low samples %0d, expected %0d", lo0, E_LAT - 1));
        for (int fr = 0; fr < FRAMES; fr++) begin
            for (int led = 0; led < N; led++) begin
                logic [23:0] c;
                logic [23:0] w;
                c = colour_of(led, fr);
                w = {c[15:8], c[23:16], c[7:0]};
                // R6 R7: address has already stepped past this LED, wrapping after the last
                check(int'(addr) == (led + 1) % N,
                      $sformatf("R6 R7 frame %0d led %0d: addr %0d, expected %0d",
                                fr, led, addr, (led + 1) % N));
                if (led == N - 1) pat = fr + 1;
                for (int b = 0; b < 24; b++) begin
                    int hi, lo, eh, el;
                    bit last;
                    last = (led == N - 1) && (b == 23);
                    eh = w[23 - b] ? E_T1H : E_T0H;
                    el = (w[23 - b] ? E_T1L : E_T0L) + (last ? E_LAT : 0);
                    measure(hi, lo);
                    // R3 R4 R5 bit shape and order; R2 for the gap after the last bit
                    check(hi == eh && lo == el,
                          $sformatf("R3 R4 R5 R2 frame %0d led %0d bit %0d: high %0d low %0d, expected high %0d low %0d",
                                    fr, led, b, hi, lo, eh, el));
                end
            end
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule